// File: doc/BRIEF.md
# Variable-Size Cyclic Lane Rotator

This block is the permutation network of a partly parallel iterative decoder. It takes a vector of up to `LANES` message lanes, each `MSG_W` bits wide, and rotates the lowest `z` lanes cyclically by a shift amount `s`. This applies one cyclically offset identity sub-matrix to a block of messages. The sub-block size `z` is not fixed to a power of two. A size-select input picks it as `z = ZMIN + sel*ZSTEP`, which by default gives 19 sizes from 24 to 96 in steps of 4. The wrap-around therefore happens at lane `z` and not at the top of the vector.

The network is a chain of logarithmic stages. Stage `k` moves data by `2^k` lanes when bit `k` of the shift is set, and each stage folds its own wrap at the selected `z`. A register after the middle stage (parameter `PIPE`, default 1) gives a fixed latency of one clock. Lanes at and above `z` are driven to zero. A shift that is not below `z`, or a size select outside the supported range, raises an error flag and blanks the whole output vector.

Top module: `rot_lane_net`

## Requirements
- R1: For a legal size select `sel` (0..18 by default), `z = 24 + 4*sel` and a shift `s < z`, output lane `i < z` equals input lane `(i + s) mod z`.
- R2: For legal inputs, every output lane with index `i >= z` is zero.
- R3: A shift `s >= z` with a legal size select sets `err_o` to 1 and drives all output lanes to zero.
- R4: A size select above 18 sets `err_o` to 1 and drives all output lanes to zero, whatever the shift.
- R5: A shift of 0 passes lanes `0..z-1` through unchanged.
- R6: With `PIPE=1`, the outputs show the result for the inputs sampled at the previous rising clock edge and hold steady between edges. While `rst_ni` is low, `data_o` is all zero and `err_o` is 0.
- R7: The wrap is correct at the extreme sizes `z = 96` (the whole vector) and `z = 24` (the smallest block).
- R8: A shift of `z-1` moves input lane `z-1` to output lane 0, and input lane `i-1` to output lane `i` for `1 <= i < z`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the middle pipeline register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | LANES x MSG_W | Input lane vector, lane 0 in the low bits |
| shift_i | input | clog2(LANES) | Rotation amount `s` |
| size_sel_i | input | clog2(NSEL) | Size select, `z = ZMIN + sel*ZSTEP` |
| data_o | output | LANES x MSG_W | Rotated vector, zero above lane `z-1` |
| err_o | output | 1 | Illegal shift or size select |

## Verification
The rotation is driven with a lane-index ramp, so that a lane moved by the wrong amount or folded at the wrong boundary shows up as a wrong value. It is also driven with random lane data, so that bits stuck in a lane or swapped between lanes are caught. For every one of the 19 sizes, the shifts 0, 1, `z/2`, `z-1` and `z` are applied. These separate pass-through, the single-step move, a move through the middle stages, the full wrap, and the first illegal shift. Size selects past the table, and random shifts up to the full shift width, test the blanking with the error flag. A hold check after each change of input shows the one-cycle latency.

// File: rtl/rot_pkg.sv
package rot_pkg;

   // Sub-block size selected by a size code.
   function automatic int size_of_sel(input int sel, input int zmin, input int zstep);
      return zmin + sel * zstep;
   endfunction

   // Number of selectable sizes between zmin and lanes.
   function automatic int num_sizes(input int lanes, input int zmin, input int zstep);
      return (lanes - zmin) / zstep + 1;
   endfunction

endpackage

// File: rtl/rot_stage.sv
module rot_stage #(
   parameter int LANES = 96,
   parameter int MSG_W = 9,
   parameter int STEP  = 1,
   parameter int ZW    = 7
) (
   input  logic                        en_i,
   input  logic [ZW-1:0]               z_i,
   input  logic [LANES-1:0][MSG_W-1:0] d_i,
   output logic [LANES-1:0][MSG_W-1:0] d_o
);

   localparam int AW = $clog2(LANES) + 1;

   if (STEP >= LANES) begin : g_bad_step
      $error("rot_stage: STEP must be below LANES");
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         automatic int src = i + STEP;
         if (src >= int'(z_i)) src = src - int'(z_i);
         if (!en_i) begin
            d_o[i] = d_i[i];
         end else if (i < int'(z_i) && src >= 0 && src < LANES) begin
            d_o[i] = d_i[AW'(src)];
         end else begin
            d_o[i] = '0;
         end
      end
      // R1: lane 0 of an enabled stage picks lane STEP when no wrap is possible
      if (en_i && int'(z_i) > STEP && int'(z_i) <= LANES) begin
         p_lane0_step_r1: assert (d_o[0] == d_i[STEP]);
      end
   end

endmodule

// File: rtl/rot_mask.sv
module rot_mask #(
   parameter int LANES = 96,
   parameter int MSG_W = 9,
   parameter int ZW    = 7
) (
   input  logic                        err_i,
   input  logic [ZW-1:0]               z_i,
   input  logic [LANES-1:0][MSG_W-1:0] d_i,
   output logic [LANES-1:0][MSG_W-1:0] d_o
);

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         d_o[i] = (!err_i && i < int'(z_i)) ? d_i[i] : '0;
      end
   end

endmodule

// File: rtl/rot_lane_net.sv
module rot_lane_net #(
   parameter int LANES = 96,
   parameter int MSG_W = 9,
   parameter int ZMIN  = 24,
   parameter int ZSTEP = 4,
   parameter int PIPE  = 1,
   localparam int NSEL  = rot_pkg::num_sizes(LANES, ZMIN, ZSTEP),
   localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1,
   localparam int SH_W  = $clog2(LANES)
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [LANES-1:0][MSG_W-1:0] data_i,
   input  logic [SH_W-1:0]             shift_i,
   input  logic [SEL_W-1:0]            size_sel_i,
   output logic [LANES-1:0][MSG_W-1:0] data_o,
   output logic                        err_o
);

   localparam int ZW   = $clog2(LANES + 1);
   localparam int NSTG = SH_W;
   localparam int MID  = NSTG / 2;

   typedef logic [LANES-1:0][MSG_W-1:0] vec_t;

   // elaboration-time parameter checks
   if (LANES < 4) begin : g_chk_lanes
      $error("rot_lane_net: LANES must be at least 4");
   end
   if (ZMIN < 1 || ZMIN > LANES || ZSTEP < 1) begin : g_chk_zmin
      $error("rot_lane_net: ZMIN/ZSTEP out of range");
   end
   if (((LANES - ZMIN) % ZSTEP) != 0) begin : g_chk_grid
      $error("rot_lane_net: LANES must lie on the size grid");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_chk_pipe
      $error("rot_lane_net: PIPE must be 0 or 1");
   end

   // size decode and legality
   logic          sel_bad;
   logic [ZW-1:0] z_in;
   logic          err_in;

   always_comb begin
      sel_bad = int'(size_sel_i) > NSEL - 1;
      z_in    = sel_bad ? ZW'(LANES)
                        : ZW'(rot_pkg::size_of_sel(int'(size_sel_i), ZMIN, ZSTEP));
      err_in  = sel_bad || (int'(shift_i) >= int'(z_in));
   end

   // stage data
   vec_t stg_in  [NSTG];
   vec_t stg_out [NSTG];

   // middle pipeline boundary
   vec_t            d_q;
   logic [ZW-1:0]   z_q;
   logic [SH_W-1:0] sh_q;
   logic            err_q;

   if (PIPE == 1) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            d_q   <= '0;
            z_q   <= ZW'(LANES);
            sh_q  <= '0;
            err_q <= 1'b0;
         end else begin
            d_q   <= stg_out[MID-1];
            z_q   <= z_in;
            sh_q  <= shift_i;
            err_q <= err_in;
         end
      end
   end else begin : g_comb
      assign d_q   = stg_out[MID-1];
      assign z_q   = z_in;
      assign sh_q  = shift_i;
      assign err_q = err_in;
   end

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      logic          en;
      logic [ZW-1:0] zs;
      if (k == 0) begin : g_first
         assign stg_in[k] = data_i;
      end else if (k == MID) begin : g_mid
         assign stg_in[k] = d_q;
      end else begin : g_chain
         assign stg_in[k] = stg_out[k-1];
      end
      if (k < MID) begin : g_front
         assign en = shift_i[k];
         assign zs = z_in;
      end else begin : g_back
         assign en = sh_q[k];
         assign zs = z_q;
      end
      rot_stage #(
         .LANES (LANES),
         .MSG_W (MSG_W),
         .STEP  (1 << k),
         .ZW    (ZW)
      ) u_stage (
         .en_i (en),
         .z_i  (zs),
         .d_i  (stg_in[k]),
         .d_o  (stg_out[k])
      );
   end

   rot_mask #(
      .LANES (LANES),
      .MSG_W (MSG_W),
      .ZW    (ZW)
   ) u_mask (
      .err_i (err_q),
      .z_i   (z_q),
      .d_i   (stg_out[NSTG-1]),
      .d_o   (data_o)
   );

   assign err_o = err_q;

   // ---------------- assertions ----------------
   logic seen;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen <= 1'b0;
      else         seen <= 1'b1;
   end

   // R3: an error always comes with a blank vector
   p_err_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (data_o == '0));

   if (PIPE == 1) begin : g_sva_pipe
      // R4: an out-of-table size select is flagged one cycle later
      p_sel_bad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (seen && (int'($past(size_sel_i)) > NSEL - 1)) |-> err_o);
   end else begin : g_sva_comb
      // R4: an out-of-table size select is flagged at once
      p_sel_bad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (int'(size_sel_i) > NSEL - 1) |-> err_o);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_sva_lane
      // R2: lanes at or above the block size stay zero
      p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (l >= int'(z_q)) |-> (data_o[l] == '0));
   end

endmodule

// File: tb/test_rot_lane_net.sv
`timescale 1ns/1ps
module test_rot_lane_net;

   localparam int LANES = 96;
   localparam int MSG_W = 9;
   localparam int ZMIN  = 24;
   localparam int ZSTEP = 4;
   localparam int NSEL  = 19;

   typedef logic [LANES-1:0][MSG_W-1:0] vec_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   vec_t       din = '0;
   logic [6:0] shift = '0;
   logic [4:0] sel = '0;
   vec_t       dout;
   logic       err;

   always #5 clk = ~clk;

   rot_lane_net #(
      .LANES (LANES),
      .MSG_W (MSG_W),
      .ZMIN  (ZMIN),
      .ZSTEP (ZSTEP),
      .PIPE  (1)
   ) i_rot_lane_net (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .data_i     (din),
      .shift_i    (shift),
      .size_sel_i (sel),
      .data_o     (dout),
      .err_o      (err)
   );

   int    n_vec  = 0;
   int    n_fail = 0;
   bit    done   = 0;

   // pending expectation, one cycle behind the inputs
   vec_t  pend_e;
   logic  pend_er;
   string pend_tag;
   int    pend_z;
   bit    pend_v = 0;

   function automatic void model(input vec_t d, input int s, input int sl,
                                 output vec_t e, output logic er, output int z);
      bit legal;
      z     = (sl <= NSEL - 1) ? ZMIN + sl * ZSTEP : LANES;
      legal = (sl <= NSEL - 1) && (s < z);
      er    = !legal;
      for (int i = 0; i < LANES; i++)
         e[i] = (legal && i < z) ? d[(i + s) % z] : '0;
   endfunction

   function automatic string req_of(input int s, input int sl);
      int z;
      if (sl > NSEL - 1) return "R4";
      z = ZMIN + sl * ZSTEP;
      if (s >= z)         return "R3";
      if (s == 0)         return "R5";
      if (s == z - 1)     return "R8";
      if (z == LANES || z == ZMIN) return "R7";
      return "R1";
   endfunction

   task automatic compare(input string tag, input vec_t e, input logic er, input int z);
      int bad = -1;
      string t = tag;
      n_vec++;
      for (int i = 0; i < LANES; i++)
         if (bad < 0 && dout[i] !== e[i]) bad = i;
      if (bad >= 0 && !er && bad >= z) t = "R2";
      if (err !== er) begin
         n_fail++;
         $display("FAIL %s err_o act=%b exp=%b", t, err, er);
      end else if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s lane %0d act=%h exp=%h", t, bad, dout[bad], e[bad]);
      end
   endtask

   task automatic apply(input vec_t d, input int s, input int sl);
      vec_t e; logic er; int z;
      @(negedge clk);
      if (pend_v) compare(pend_tag, pend_e, pend_er, pend_z);
      din   = d;
      shift = 7'(s);
      sel   = 5'(sl);
      #1;
      if (pend_v) begin
         // R6: outputs hold until the next rising edge
         n_vec++;
         if (dout !== pend_e || err !== pend_er) begin
            n_fail++;
            $display("FAIL R6 hold act_err=%b exp_err=%b", err, pend_er);
         end
      end
      model(d, s, sl, e, er, z);
      pend_e = e; pend_er = er; pend_z = z;
      pend_tag = req_of(s, sl);
      pend_v = 1;
   endtask

   function automatic vec_t ramp();
      vec_t v;
      for (int i = 0; i < LANES; i++) v[i] = MSG_W'(i + 1);
      return v;
   endfunction

   function automatic vec_t rnd_vec();
      vec_t v;
      for (int i = 0; i < LANES; i++) v[i] = MSG_W'($urandom);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      din   = rnd_vec();
      shift = 7'd5;
      sel   = 5'd3;
      repeat (3) @(negedge clk);
      // R6: reset state
      n_vec++;
      if (dout !== '0 || err !== 1'b0) begin
         n_fail++;
         $display("FAIL R6 reset act_err=%b exp_err=0 act_lane0=%h exp_lane0=0", err, dout[0]);
      end
      rst_n = 1'b1;

      // directed sweep over all sizes
      for (int sl = 0; sl < NSEL; sl++) begin
         automatic int z = ZMIN + sl * ZSTEP;
         apply(ramp(), 0, sl);          // R5
         apply(ramp(), 1, sl);          // R1
         apply(rnd_vec(), z / 2, sl);   // R1
         apply(ramp(), z - 1, sl);      // R8
         apply(rnd_vec(), z, sl);       // R3
         apply(rnd_vec(), int'($urandom % z), sl);
      end

      // extreme sizes, R7
      apply(ramp(), 95, NSEL - 1);
      apply(ramp(), 64, NSEL - 1);
      apply(ramp(), 23, 0);
      apply(ramp(), 127, NSEL - 1);     // R3

      // out-of-table size select, R4
      apply(ramp(), 0, 19);
      apply(ramp(), 7, 31);
      apply(rnd_vec(), 3, 25);

      // random mix
      for (int n = 0; n < 400; n++)
         apply(rnd_vec(), int'($urandom % 128), int'($urandom % 22));

      @(negedge clk);
      if (pend_v) compare(pend_tag, pend_e, pend_er, pend_z);
      pend_v = 0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule